// File: doc/BRIEF.md
# Nonvolatile Memory Write Qualifier

This block sits between the asynchronous control pins of a parallel nonvolatile memory and its internal write state machine. It decides whether a low phase of the chip-enable and write-enable strobes is a real write. Only then does it hand the write state machine a one-cycle start pulse, together with the address and data captured for that write.

A write is refused in four cases. The supply comparator reports low supply. The supply has not yet been good for a settling interval after power-up or after a dip. The output-enable pin is low. The overlap of the two strobes is too short to be anything but noise. All pin inputs, the supply flag included, are brought into the clock domain through two-flop synchronizers. The strobe overlap is then measured in clock cycles. The settling interval and the minimum overlap are parameters in clock cycles. The defaults are 375000 cycles (7.5 ms at 50 MHz) and 2 cycles (40 ns at 50 MHz, above the 20 ns noise limit).

Top module: `nvm_wr_guard`

## Requirements
- R1: After reset, `wr_pulse` is 0 and `wr_addr` and `wr_data` are all zeros.
- R2: While `sup_fail_n` is low (supply below threshold), no `wr_pulse` is issued, whatever the strobes do.
- R3: After `sup_fail_n` goes high, writes remain refused until the supply has been good for `HOLDOFF_CYC` consecutive clock cycles. After that, a valid strobe sequence produces a write.
- R4: Any low cycle of `sup_fail_n` restarts the settling interval from zero, so a write that starts right after a short dip is refused.
- R5: While `oe_n` is low, no `wr_pulse` is issued.
- R6: A write needs `ce_n` and `we_n` low at the same time. A low phase on only one of them, with the other held high, never produces `wr_pulse`.
- R7: A strobe overlap (both low) that lasts fewer than `MIN_LOW_CYC` clock cycles is ignored. An overlap of exactly `MIN_LOW_CYC` cycles is accepted.
- R8: An accepted write gives exactly one `wr_pulse`, high for a single cycle. The pulse is high in the third clock cycle after the edge on which the first of the two strobes returns high. This holds for both the write-enable-controlled order and the chip-enable-controlled order.
- R9: `wr_addr` and `wr_data` take the values of `addr_in` and `data_in` from the start of the strobe overlap. They hold those values while `wr_pulse` is high, even if the inputs change later in the overlap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sup_fail_n | input | 1 | Supply comparator result, low when the supply is below threshold |
| ce_n | input | 1 | Chip enable pin, active low, asynchronous |
| oe_n | input | 1 | Output enable pin, active low, asynchronous |
| we_n | input | 1 | Write enable pin, active low, asynchronous |
| addr_in | input | ADDR_W | Address pins |
| data_in | input | DATA_W | Data pins |
| wr_pulse | output | 1 | One-cycle write start to the write state machine |
| wr_addr | output | ADDR_W | Address captured for the write |
| wr_data | output | DATA_W | Data captured for the write |

## Verification
The hardest situation to reach is the boundary of the width filter. There, overlaps one cycle apart must give opposite results, and the pulse must land in one exact cycle. The bench changes every pin on the falling clock edge so that each low phase spans a known number of sampling edges. It then drives overlaps of exactly one below and exactly at the minimum, in both strobe orders. The settling interval is made short through its parameter. This lets the bench reach both the refusal just after supply rise and the restart after a three-cycle dip.

// File: rtl/nvm_wg_pkg.sv
package nvm_wg_pkg;

    // Synchronized view of the asynchronous control pins
    typedef struct packed {
        logic sup_ok;
        logic oe_n;
        logic we_n;
        logic ce_n;
    } pin_vec_t;

    localparam int unsigned PIN_W = $bits(pin_vec_t);

    // Safe value while in reset: supply treated as failed, pins idle
    localparam pin_vec_t PIN_IDLE = '{sup_ok: 1'b0, oe_n: 1'b1, we_n: 1'b1, ce_n: 1'b1};

endpackage

// File: rtl/nvm_wg_sync.sv
module nvm_wg_sync #(
    parameter int unsigned     W       = 4,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] meta_d, meta_q;
    logic [W-1:0] stab_d, stab_q;

    // Each bit gets its own independent two-stage chain
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_comb begin
            meta_d[b] = async_in[b];
            stab_d[b] = meta_q[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= meta_d;
            stab_q <= stab_d;
        end
    end

    assign sync_out = stab_q;

endmodule

// File: rtl/nvm_wg_holdoff.sv
module nvm_wg_holdoff #(
    parameter int unsigned HOLDOFF_CYC = 375000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_ok,
    output logic ready
);

    localparam int unsigned CW = (HOLDOFF_CYC < 2) ? 1 : $clog2(HOLDOFF_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLDOFF_CYC - 1);

    typedef struct packed {
        logic          ready;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!sup_ok) begin
            // Any supply dip discards the progress made so far
            st_d = '0;
        end else if (!st_q.ready) begin
            if (st_q.cnt == LAST) begin
                st_d.ready = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready = st_q.ready;

endmodule

// File: rtl/nvm_wg_qual.sv
module nvm_wg_qual #(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned MIN_LOW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_s,
    input  logic              we_s,
    input  logic              oe_s,
    input  logic              enable,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              wr_pulse,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam int unsigned GW = (MIN_LOW < 2) ? 1 : $clog2(MIN_LOW + 1);
    localparam logic [GW-1:0] GMAX = GW'(MIN_LOW);

    typedef struct packed {
        logic [GW-1:0]     width;
        logic              pulse;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } st_t;

    st_t  st_d, st_q;
    logic overlap;
    logic allowed;
    logic long_enough;

    always_comb begin
        overlap     = !ce_s && !we_s;
        allowed     = enable && oe_s;
        long_enough = (st_q.width == GMAX);

        st_d       = st_q;
        st_d.pulse = 1'b0;

        if (!allowed) begin
            // An inhibit anywhere in the phase aborts it
            st_d.width = '0;
        end else if (overlap) begin
            if (st_q.width == '0) begin
                st_d.addr = addr_in;
                st_d.data = data_in;
            end
            if (!long_enough) begin
                st_d.width = st_q.width + 1'b1;
            end
        end else begin
            // Overlap just ended: issue the write if it was wide enough
            st_d.pulse = long_enough;
            st_d.width = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_pulse = st_q.pulse;
    assign wr_addr  = st_q.addr;
    assign wr_data  = st_q.data;

endmodule

// File: rtl/nvm_wr_guard.sv
module nvm_wr_guard
    import nvm_wg_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned HOLDOFF_CYC = 375000,
    parameter int unsigned MIN_LOW_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sup_fail_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              wr_pulse,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    pin_vec_t pins_raw;
    pin_vec_t pins_s;
    logic     ready;
    logic     enable;

    always_comb begin
        pins_raw.sup_ok = sup_fail_n;
        pins_raw.oe_n   = oe_n;
        pins_raw.we_n   = we_n;
        pins_raw.ce_n   = ce_n;
    end

    nvm_wg_sync #(
        .W       (PIN_W),
        .RST_VAL (PIN_IDLE)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pins_raw),
        .sync_out (pins_s)
    );

    nvm_wg_holdoff #(
        .HOLDOFF_CYC (HOLDOFF_CYC)
    ) holdoff_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sup_ok (pins_s.sup_ok),
        .ready  (ready)
    );

    // The live supply level gates at once, without waiting for the timer
    assign enable = ready && pins_s.sup_ok;

    nvm_wg_qual #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .MIN_LOW (MIN_LOW_CYC)
    ) qual_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_s     (pins_s.ce_n),
        .we_s     (pins_s.we_n),
        .oe_s     (pins_s.oe_n),
        .enable   (enable),
        .addr_in  (addr_in),
        .data_in  (data_in),
        .wr_pulse (wr_pulse),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

endmodule

// File: rtl/nvm_wr_guard_chk.sv
module nvm_wr_guard_chk #(
    parameter int unsigned HOLDOFF_CYC = 375000
) (
    input logic clk,
    input logic rst_n,
    input logic sup_fail_n,
    input logic ce_n,
    input logic oe_n,
    input logic we_n,
    input logic wr_pulse
);

    localparam int unsigned RW = (HOLDOFF_CYC < 2) ? 1 : $clog2(HOLDOFF_CYC + 1);
    localparam logic [RW-1:0] RMAX = RW'(HOLDOFF_CYC);

    logic [1:0]    sup_low_run_q, oe_low_run_q;
    logic [2:0]    ce_hi_run_q, we_hi_run_q;
    logic [RW-1:0] good_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sup_low_run_q <= '0;
            oe_low_run_q  <= '0;
            ce_hi_run_q   <= '0;
            we_hi_run_q   <= '0;
            good_run_q    <= '0;
        end else begin
            sup_low_run_q <= sup_fail_n ? 2'd0 : ((sup_low_run_q == 2'd3) ? 2'd3 : sup_low_run_q + 2'd1);
            oe_low_run_q  <= oe_n ? 2'd0 : ((oe_low_run_q == 2'd3) ? 2'd3 : oe_low_run_q + 2'd1);
            ce_hi_run_q   <= !ce_n ? 3'd0 : ((ce_hi_run_q == 3'd4) ? 3'd4 : ce_hi_run_q + 3'd1);
            we_hi_run_q   <= !we_n ? 3'd0 : ((we_hi_run_q == 3'd4) ? 3'd4 : we_hi_run_q + 3'd1);
            good_run_q    <= !sup_fail_n ? '0 : ((good_run_q == RMAX) ? RMAX : good_run_q + 1'b1);
        end
    end

    // R2
    sup_low_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_low_run_q == 2'd3) |-> !wr_pulse);

    // R3 R4
    holdoff_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (good_run_q < RMAX) |-> !wr_pulse);

    // R5
    oe_low_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_low_run_q == 2'd3) |-> !wr_pulse);

    // R6
    strobe_high_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ce_hi_run_q == 3'd4) || (we_hi_run_q == 3'd4)) |-> !wr_pulse);

    // R8
    pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

endmodule

bind nvm_wr_guard nvm_wr_guard_chk #(
    .HOLDOFF_CYC (HOLDOFF_CYC)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sup_fail_n (sup_fail_n),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .we_n       (we_n),
    .wr_pulse   (wr_pulse)
);

// File: tb/nvm_wr_guard_tb_top.sv
module nvm_wr_guard_tb_top;

    localparam int unsigned AW = 16;
    localparam int unsigned DW = 8;
    localparam int unsigned HO = 40;
    localparam int unsigned ML = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sup_fail_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          we_n = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] data_in = '0;
    logic          wr_pulse;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nvm_wr_guard #(
        .ADDR_W (AW), .DATA_W (DW), .HOLDOFF_CYC (HO), .MIN_LOW_CYC (ML)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .sup_fail_n (sup_fail_n),
        .ce_n (ce_n), .oe_n (oe_n), .we_n (we_n),
        .addr_in (addr_in), .data_in (data_in),
        .wr_pulse (wr_pulse), .wr_addr (wr_addr), .wr_data (wr_data)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Two strobes, overlap of 'ovl' sampling edges; pulse expected at the
    // third falling edge after the first strobe returns high.
    task automatic write_seq(input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input bit we_falls_first, input int ovl,
                             input bit we_rises_first, input bit expect_wr,
                             input bit change_mid, input string req);
        logic [5:0] seen = '0;
        logic [5:0] want = expect_wr ? 6'b000100 : 6'b000000;
        bit data_ok = 1'b1;
        @(negedge clk);
        addr_in = a; data_in = d;
        if (we_falls_first) we_n = 1'b0; else ce_n = 1'b0;
        repeat (2) @(negedge clk);
        if (we_falls_first) ce_n = 1'b0; else we_n = 1'b0;
        for (int i = 0; i < ovl; i++) begin
            @(negedge clk);
            if (change_mid && i == 3) begin
                addr_in = ~a; data_in = ~d;
            end
        end
        if (we_rises_first) we_n = 1'b1; else ce_n = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            seen[k-1] = wr_pulse;
            if (wr_pulse && (wr_addr != a || wr_data != d)) data_ok = 1'b0;
            if (k == 1) begin
                ce_n = 1'b1; we_n = 1'b1;
            end
        end
        check(seen == want && data_ok, req, {26'd0, seen}, {26'd0, want});
    endtask

    task automatic single_strobe(input bit use_we, input string req);
        int pulses = 0;
        @(negedge clk);
        if (use_we) we_n = 1'b0; else ce_n = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            pulses += int'(wr_pulse);
        end
        we_n = 1'b1; ce_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            pulses += int'(wr_pulse);
        end
        check(pulses == 0, req, pulses, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(wr_pulse == 1'b0, "R1 pulse", wr_pulse, 0);
        check(wr_addr == '0, "R1 addr", wr_addr, 0);
        check(wr_data == '0, "R1 data", wr_data, 0);
    endtask

    task automatic t_supply_low();
        write_seq(16'h1234, 8'h5A, 1'b0, 8, 1'b1, 1'b0, 1'b0, "R2 supply low");
    endtask

    task automatic t_holdoff();
        @(negedge clk); sup_fail_n = 1'b1;
        write_seq(16'h2222, 8'h11, 1'b0, 6, 1'b1, 1'b0, 1'b0, "R3 early write");
        repeat (HO + 10) @(negedge clk);
        write_seq(16'h3333, 8'h22, 1'b0, 6, 1'b1, 1'b1, 1'b0, "R3 after settle");
    endtask

    task automatic t_orders();
        write_seq(16'hA001, 8'hC1, 1'b0, 5, 1'b1, 1'b1, 1'b0, "R8 we-controlled");
        write_seq(16'hA002, 8'hC2, 1'b1, 5, 1'b0, 1'b1, 1'b0, "R8 ce-controlled");
        write_seq(16'hA003, 8'hC3, 1'b0, 20, 1'b1, 1'b1, 1'b0, "R8 long overlap");
    endtask

    task automatic t_glitch();
        write_seq(16'hB001, 8'hD1, 1'b0, ML - 1, 1'b1, 1'b0, 1'b0, "R7 we glitch");
        write_seq(16'hB002, 8'hD2, 1'b1, ML - 1, 1'b0, 1'b0, 1'b0, "R7 ce glitch");
        write_seq(16'hB003, 8'hD3, 1'b0, ML, 1'b1, 1'b1, 1'b0, "R7 minimum we");
        write_seq(16'hB004, 8'hD4, 1'b1, ML, 1'b0, 1'b1, 1'b0, "R7 minimum ce");
    endtask

    task automatic t_oe();
        @(negedge clk); oe_n = 1'b0;
        write_seq(16'hC001, 8'hE1, 1'b0, 6, 1'b1, 1'b0, 1'b0, "R5 oe low");
        @(negedge clk); oe_n = 1'b1;
        write_seq(16'hC002, 8'hE2, 1'b0, 6, 1'b1, 1'b1, 1'b0, "R5 oe high");
    endtask

    task automatic t_single();
        single_strobe(1'b1, "R6 we only");
        single_strobe(1'b0, "R6 ce only");
    endtask

    task automatic t_capture();
        write_seq(16'h0F0F, 8'h3C, 1'b0, 8, 1'b1, 1'b1, 1'b1, "R9 capture");
        @(negedge clk);
        check(wr_addr == 16'h0F0F, "R9 held addr", wr_addr, 16'h0F0F);
    endtask

    task automatic t_dip();
        @(negedge clk); sup_fail_n = 1'b0;
        repeat (3) @(negedge clk);
        sup_fail_n = 1'b1;
        write_seq(16'hD001, 8'hF1, 1'b0, 6, 1'b1, 1'b0, 1'b0, "R4 after dip");
        repeat (HO + 10) @(negedge clk);
        write_seq(16'hD002, 8'hF2, 1'b0, 6, 1'b1, 1'b1, 1'b0, "R4 resettled");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_supply_low();
        t_holdoff();
        t_orders();
        t_glitch();
        t_oe();
        t_single();
        t_capture();
        t_dip();
        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule